// File: doc/BRIEF.md
# Accumulator Round-and-Clamp Converter

This block narrows wide per-lane accumulator values into one 64-bit packed result. The accumulator bus is 192 bits wide and is read in one of two ways. In halfword format it holds four signed 48-bit lanes, and each lane becomes a 16-bit field. In byte format it holds eight 24-bit lanes, and each lane becomes an 8-bit field. Every lane is shifted right by its own amount. That amount comes from one of three places: the matching field of a shift vector, one field of that vector broadcast to every lane, or a 5-bit unsigned immediate. The shifted value is then rounded by one of six modes and saturated to the width of the output field.

The mode code (`rmode`) picks the rounding:

| Code | Rounding | Signedness |
|------|----------|------------|
| 0 | nearest, ties away | signed |
| 1 | nearest, ties away | unsigned |
| 2 | nearest, ties to even | signed |
| 3 | nearest, ties to even | unsigned |
| 4 | truncate | signed |
| 5 | truncate | unsigned |

Byte format accepts only the odd codes.

An operation starts with a one-cycle `start` pulse and is controlled by a three-state machine:
- ST_IDLE: `ready` is high. If `start` is high at a clock edge, the inputs are latched and the machine moves to ST_EVAL.
- ST_EVAL: the lane converters work on the latched inputs. The packed result and the flag are registered, and the machine moves to ST_OUT.
- ST_OUT: `done` is high for this one cycle only. The machine then returns to ST_IDLE.

`result` and `unpred` hold their values until the next operation writes them.

Top module: `acc_round_clamp`

## Requirements
- R1: After reset, `result` is 0, `unpred` is 0, `done` is 0 and `ready` is 1.
- R2: Latency and start handling:
  - A `start` seen in ST_IDLE makes `done` high for exactly one cycle, two clock edges after the accepting edge.
  - `start` has no effect while `ready` is low.
  - `result` changes only on the edge that leaves ST_EVAL.
- R3: Mode 1 (unsigned, ties away) first takes the lane value shifted right by s. If bit s-1 of the accumulator is set, it adds 1.
- R4: Mode 0 (signed, ties away) uses an arithmetic shift right by s.
  - For a non-negative accumulator (bit 47 clear), it adds 1 when bit s-1 is set.
  - For a negative accumulator, it adds 1 only when bit s-1 is set and some bit below s-1 is also set.
- R5: Modes 2 (signed) and 3 (unsigned) round to nearest with ties to even.
  - If bit s-1 is set and a lower bit is set, the shifted value gets 1 added.
  - If bit s-1 is set and all lower bits are zero, the shifted value gets its own LSB added.
- R6: Modes 4 (signed) and 5 (unsigned) return the shifted value with no increment.
- R7: Saturation happens after any increment, computed at full width.
  - Signed results saturate to 0x8000 when bit 47 is set and to 0x7FFF when it is clear.
  - Unsigned results treat the lane as unsigned and saturate to 0xFFFF (halfword) or 0xFF (byte).
- R8: Large shifts give 0:
  - in halfword format, a shift above 48;
  - in modes 2 and 4, a shift above 47;
  - in byte format, a shift above 24.
- R9: At a shift of exactly 48 (halfword) or 24 (byte):
  - mode 1 returns the top lane bit;
  - mode 3 returns 1 only if the unsigned lane value exceeds 2^47 (or 2^23);
  - halfword mode 5 follows the same rule as mode 3.
- R10: The shift source is set by `shsrc`:
  - 0 gives each lane its own field of `shvec` (16 bits per lane in halfword format, 8 bits in byte format);
  - 1 broadcasts the field indexed by `elem_sel` (bits 1:0 in halfword format);
  - 2 or 3 uses `shimm` for every lane.
- R11: Byte format gives eight 8-bit lanes from 24-bit accumulators, with lane i at result bits 8i+7:8i.
  - An even mode code in byte format, or code 6 or 7 in either format, raises `unpred`.
  - Every lane then becomes filler: 0xAD in byte format, 0xDEAD in halfword format.
- R12: In halfword format, a shift field with bit 15 set is negative.
  - That lane becomes 0xDEAD and `unpred` rises.
  - The other lanes convert normally.
  - Byte-format shift fields are unsigned and never raise `unpred`.
- R13: In byte format, mode 5 gives 0 for any shift of 24 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when `ready`) |
| byte_fmt | input | 1 | 1 = eight 24-bit lanes, 0 = four 48-bit lanes |
| rmode | input | 3 | Rounding mode code 0..5 |
| shsrc | input | 2 | Shift source: 0 per-lane, 1 broadcast field, 2/3 immediate |
| elem_sel | input | 3 | Field index for broadcast shift |
| shvec | input | 64 | Packed shift fields |
| shimm | input | 5 | Immediate shift amount |
| acc_bus | input | 192 | Packed accumulator lanes |
| result | output | 64 | Packed rounded and saturated lanes |
| unpred | output | 1 | Some lane's result is unpredictable |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Machine is in ST_IDLE |

## Verification
The assertions assume that every input is known whenever `start` is high in ST_IDLE. They also assume that `start` is not raised before reset has been released. They do not constrain the inputs while the machine is busy, because the latched copies shield the datapath from those values. The stimulus drives every input away from the clock edge and keeps each field known before `start`. It also changes the inputs on purpose while the machine is busy, to show that those changes are ignored.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int HW_LANES = 4;
    localparam int HW_ACC   = 48;
    localparam int HW_OUT   = 16;
    localparam int BY_LANES = 8;
    localparam int BY_ACC   = 24;
    localparam int BY_OUT   = 8;
    localparam int SHV_W    = HW_LANES * HW_OUT;
    localparam int ACC_W    = HW_LANES * HW_ACC;
    localparam int IMM_W    = 5;
    localparam int SHAMT_W  = 6;
    localparam int SEL_W    = $clog2(BY_LANES);

    localparam logic [HW_OUT-1:0] HW_FILL = 16'hDEAD;
    localparam logic [BY_OUT-1:0] BY_FILL = 8'hAD;

    localparam logic [2:0] RM_NA_S = 3'd0;
    localparam logic [2:0] RM_NA_U = 3'd1;
    localparam logic [2:0] RM_NE_S = 3'd2;
    localparam logic [2:0] RM_NE_U = 3'd3;
    localparam logic [2:0] RM_TR_S = 3'd4;
    localparam logic [2:0] RM_TR_U = 3'd5;

    localparam logic [1:0] SRC_VEC  = 2'd0;
    localparam logic [1:0] SRC_ELEM = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_OUT  = 2'd2
    } rc_state_e;

    function automatic logic [HW_OUT-1:0] sat_signed(input logic signed [63:0] t, input logic neg);
        if (neg)
            sat_signed = (t < -64'sd32768) ? 16'h8000 : t[HW_OUT-1:0];
        else
            sat_signed = (t > 64'sd32767) ? 16'h7FFF : t[HW_OUT-1:0];
    endfunction

    function automatic logic [HW_OUT-1:0] sat_unsigned(input logic [63:0] t, input logic [63:0] umax);
        sat_unsigned = (t > umax) ? umax[HW_OUT-1:0] : t[HW_OUT-1:0];
    endfunction
endpackage

// File: rtl/rc_shift_pick.sv
module rc_shift_pick
    import rc_pkg::*;
(
    input  logic                             byte_fmt,
    input  logic [1:0]                       src,
    input  logic [SEL_W-1:0]                 lane_sel,
    input  logic [SHV_W-1:0]                 shift_vec,
    input  logic [IMM_W-1:0]                 shift_imm,
    output logic [BY_LANES-1:0][SHAMT_W-1:0] shamt,
    output logic [BY_LANES-1:0]              neg
);
    localparam logic [SHAMT_W-1:0] SH_CLIP = '1;

    logic [HW_OUT-1:0] hw_elem;
    logic [BY_OUT-1:0] by_elem;

    assign hw_elem = shift_vec[HW_OUT*lane_sel[1:0] +: HW_OUT];
    assign by_elem = shift_vec[BY_OUT*lane_sel +: BY_OUT];

    for (genvar i = 0; i < BY_LANES; i++) begin : g_lane
        logic [HW_OUT-1:0]  hw_raw;
        logic [BY_OUT-1:0]  by_raw;
        logic [SHAMT_W-1:0] l_shamt;
        logic               l_neg;

        if (i < HW_LANES) begin : g_hw
            assign hw_raw = (src == SRC_VEC)  ? shift_vec[HW_OUT*i +: HW_OUT] :
                            (src == SRC_ELEM) ? hw_elem :
                            {{(HW_OUT-IMM_W){1'b0}}, shift_imm};
        end else begin : g_nohw
            assign hw_raw = '0;
        end

        assign by_raw = (src == SRC_VEC)  ? shift_vec[BY_OUT*i +: BY_OUT] :
                        (src == SRC_ELEM) ? by_elem :
                        {{(BY_OUT-IMM_W){1'b0}}, shift_imm};

        always_comb begin
            l_neg = 1'b0;
            if (byte_fmt) begin
                l_shamt = (by_raw > BY_OUT'(SH_CLIP)) ? SH_CLIP : by_raw[SHAMT_W-1:0];
            end else if (hw_raw[HW_OUT-1]) begin
                l_shamt = '0;
                l_neg   = 1'b1;
            end else begin
                l_shamt = (hw_raw > HW_OUT'(SH_CLIP)) ? SH_CLIP : hw_raw[SHAMT_W-1:0];
            end
        end

        assign shamt[i] = l_shamt;
        assign neg[i]   = l_neg;
    end
endmodule

// File: rtl/rc_lane.sv
module rc_lane
    import rc_pkg::*;
(
    input  logic               byte_fmt,
    input  logic [2:0]         mode,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               neg_shift,
    input  logic [HW_ACC-1:0]  acc,
    output logic [HW_OUT-1:0]  lane_out,
    output logic               lane_bad
);
    logic               mode_ok;
    logic [63:0]        uval, uq, lowmask, umax, thr, t_u;
    logic signed [63:0] sval, sq, t_s;
    logic [6:0]         limit, s_ext;
    logic [SHAMT_W-1:0] s_m1;
    logic               half, low_nz, acc_neg, top_bit, inc;

    always_comb begin
        mode_ok = byte_fmt ? (mode == RM_NA_U || mode == RM_NE_U || mode == RM_TR_U)
                           : (mode <= RM_TR_U);
        uval    = byte_fmt ? {40'd0, acc[BY_ACC-1:0]} : {16'd0, acc};
        sval    = {{16{acc[HW_ACC-1]}}, acc};
        acc_neg = acc[HW_ACC-1];
        top_bit = byte_fmt ? acc[BY_ACC-1] : acc[HW_ACC-1];
        limit   = byte_fmt ? 7'd24 : 7'd48;
        umax    = byte_fmt ? 64'hFF : 64'hFFFF;
        thr     = byte_fmt ? 64'h80_0000 : 64'h8000_0000_0000;
        s_ext   = {1'b0, shamt};
        s_m1    = shamt - 6'd1;
        half    = (shamt != '0) && uval[s_m1];
        lowmask = (64'd1 << s_m1) - 64'd1;
        low_nz  = (shamt > 6'd1) && ((uval & lowmask) != 64'd0);
        uq      = uval >> shamt;
        sq      = sval >>> shamt;
        t_s     = '0;
        t_u     = '0;
        inc     = 1'b0;
        lane_out = '0;
        lane_bad = 1'b0;
        if (!mode_ok || neg_shift) begin
            lane_bad = 1'b1;
            lane_out = byte_fmt ? {8'h00, BY_FILL} : HW_FILL;
        end else begin
            case (mode)
                RM_NA_S: if (s_ext <= 7'd48) begin
                    inc      = acc_neg ? (half && low_nz) : half;
                    t_s      = sq + (inc ? 64'sd1 : 64'sd0);
                    lane_out = sat_signed(t_s, acc_neg);
                end
                RM_NE_S: if (s_ext <= 7'd47) begin
                    inc      = half && (low_nz || sq[0]);
                    t_s      = sq + (inc ? 64'sd1 : 64'sd0);
                    lane_out = sat_signed(t_s, acc_neg);
                end
                RM_TR_S: if (s_ext <= 7'd47) begin
                    lane_out = sat_signed(sq, acc_neg);
                end
                default: begin
                    if (s_ext == limit) begin
                        if (mode == RM_NA_U)
                            lane_out = {15'd0, top_bit};
                        else if (mode == RM_NE_U || !byte_fmt)
                            lane_out = {15'd0, (uval > thr)};
                        else
                            lane_out = '0;
                    end else if (s_ext < limit) begin
                        inc      = (mode == RM_NA_U) ? half :
                                   (mode == RM_NE_U) ? (half && (low_nz || uq[0])) : 1'b0;
                        t_u      = uq + {63'd0, inc};
                        lane_out = sat_unsigned(t_u, umax);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/acc_round_clamp.sv
module acc_round_clamp
    import rc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               byte_fmt,
    input  logic [2:0]         rmode,
    input  logic [1:0]         shsrc,
    input  logic [SEL_W-1:0]   elem_sel,
    input  logic [SHV_W-1:0]   shvec,
    input  logic [IMM_W-1:0]   shimm,
    input  logic [ACC_W-1:0]   acc_bus,
    output logic [SHV_W-1:0]   result,
    output logic               unpred,
    output logic               done,
    output logic               ready
);
    rc_state_e state_q, state_d;

    logic               fmt_q;
    logic [2:0]         mode_q;
    logic [1:0]         src_q;
    logic [SEL_W-1:0]   sel_q;
    logic [SHV_W-1:0]   svec_q;
    logic [IMM_W-1:0]   imm_q;
    logic [ACC_W-1:0]   acc_q;

    logic [BY_LANES-1:0][SHAMT_W-1:0] shamt;
    logic [BY_LANES-1:0]              neg;
    logic [BY_LANES-1:0][HW_OUT-1:0]  lane_out;
    logic [BY_LANES-1:0]              lane_bad;
    logic [SHV_W-1:0]                 res_d;
    logic                             bad_d;
    logic [SHV_W-1:0]                 result_q;
    logic                             unpred_q;

    // State register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= 1'b0;
            mode_q  <= '0;
            src_q   <= '0;
            sel_q   <= '0;
            svec_q  <= '0;
            imm_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                fmt_q  <= byte_fmt;
                mode_q <= rmode;
                src_q  <= shsrc;
                sel_q  <= elem_sel;
                svec_q <= shvec;
                imm_q  <= shimm;
                acc_q  <= acc_bus;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = ST_OUT;
            ST_OUT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    rc_shift_pick u_pick (
        .byte_fmt  (fmt_q),
        .src       (src_q),
        .lane_sel  (sel_q),
        .shift_vec (svec_q),
        .shift_imm (imm_q),
        .shamt     (shamt),
        .neg       (neg)
    );

    for (genvar i = 0; i < BY_LANES; i++) begin : g_conv
        logic [HW_ACC-1:0] lane_acc;
        if (i < HW_LANES) begin : g_wide
            assign lane_acc = fmt_q ? {{(HW_ACC-BY_ACC){1'b0}}, acc_q[BY_ACC*i +: BY_ACC]}
                                    : acc_q[HW_ACC*i +: HW_ACC];
        end else begin : g_narrow
            assign lane_acc = fmt_q ? {{(HW_ACC-BY_ACC){1'b0}}, acc_q[BY_ACC*i +: BY_ACC]} : '0;
        end
        rc_lane u_lane (
            .byte_fmt  (fmt_q),
            .mode      (mode_q),
            .shamt     (shamt[i]),
            .neg_shift (neg[i]),
            .acc       (lane_acc),
            .lane_out  (lane_out[i]),
            .lane_bad  (lane_bad[i])
        );
    end

    always_comb begin
        res_d = '0;
        bad_d = 1'b0;
        if (fmt_q) begin
            for (int i = 0; i < BY_LANES; i++) begin
                res_d[BY_OUT*i +: BY_OUT] = lane_out[i][BY_OUT-1:0];
                bad_d = bad_d | lane_bad[i];
            end
        end else begin
            for (int i = 0; i < HW_LANES; i++) begin
                res_d[HW_OUT*i +: HW_OUT] = lane_out[i];
                bad_d = bad_d | lane_bad[i];
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            unpred_q <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            result_q <= res_d;
            unpred_q <= bad_d;
        end
    end

    assign result = result_q;
    assign unpred = unpred_q;
    assign done   = (state_q == ST_OUT);
    assign ready  = (state_q == ST_IDLE);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (!ready && !done));

    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> $stable(result));

    p_byte_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_q && !mode_q[0]) |-> (unpred && result == {BY_LANES{BY_FILL}}));

    p_neg_shift_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fmt_q && src_q == SRC_VEC &&
         (svec_q[15] || svec_q[31] || svec_q[47] || svec_q[63])) |-> unpred);

    p_byte_trunc_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_q && mode_q == RM_TR_U && src_q[1] && imm_q >= 5'd24) |-> (result == '0));
endmodule

// File: tb/acc_round_clamp_tb_top.sv
`timescale 1ns/100ps
module acc_round_clamp_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         byte_fmt = 1'b0;
    logic [2:0]   rmode = '0;
    logic [1:0]   shsrc = '0;
    logic [2:0]   elem_sel = '0;
    logic [63:0]  shvec = '0;
    logic [4:0]   shimm = '0;
    logic [191:0] acc_bus = '0;
    logic [63:0]  result;
    logic         unpred, done, ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    acc_round_clamp dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_fmt(byte_fmt), .rmode(rmode),
        .shsrc(shsrc), .elem_sel(elem_sel), .shvec(shvec), .shimm(shimm),
        .acc_bus(acc_bus), .result(result), .unpred(unpred), .done(done), .ready(ready)
    );

    function automatic logic [191:0] pk4(input logic [47:0] a0, input logic [47:0] a1,
                                         input logic [47:0] a2, input logic [47:0] a3);
        return {a3, a2, a1, a0};
    endfunction

    function automatic logic [191:0] pk8(input logic [23:0] a0, input logic [23:0] a1,
                                         input logic [23:0] a2, input logic [23:0] a3,
                                         input logic [23:0] a4, input logic [23:0] a5,
                                         input logic [23:0] a6, input logic [23:0] a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic chk64(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic run_op(input logic f, input logic [2:0] m, input logic [1:0] src,
                          input logic [2:0] sel, input logic [63:0] sv, input logic [4:0] imm,
                          input logic [191:0] acc, output logic [63:0] res, output logic up);
        @(negedge clk);
        byte_fmt = f; rmode = m; shsrc = src; elem_sel = sel;
        shvec = sv; shimm = imm; acc_bus = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk1("R2 done latency", done, 1'b1);
        res = result;
        up  = unpred;
    endtask

    task automatic t_reset;
        chk64("R1 result", result, 64'd0);
        chk1("R1 unpred", unpred, 1'b0);
        chk1("R1 done", done, 1'b0);
        chk1("R1 ready", ready, 1'b1);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        byte_fmt = 0; rmode = 3'd5; shsrc = 2'd2; shimm = 5'd4;
        acc_bus = pk4(48'h10, 48'h20, 48'h30, 48'h40); start = 1'b1;
        @(negedge clk);
        chk1("R2 busy", ready, 1'b0);
        rmode = 3'd1; shimm = 5'd0; acc_bus = '0;
        @(negedge clk);
        start = 1'b0;
        chk1("R2 done", done, 1'b1);
        chk64("R2 first op kept", result, 64'h0004_0003_0002_0001);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk1("R2 single pulse", done, 1'b0);
        end
        chk64("R2 result held", result, 64'h0004_0003_0002_0001);
    endtask

    task automatic t_away_unsigned;
        logic [63:0] r; logic u;
        run_op(0, 3'd1, 2'd2, 0, 0, 5'd4, pk4(48'h18, 48'h17, 48'h28, 48'h0), r, u);
        chk64("R3 ties away unsigned", r, 64'h0000_0003_0001_0002);
        chk1("R3 flag", u, 1'b0);
    endtask

    task automatic t_away_signed;
        logic [63:0] r; logic u;
        run_op(0, 3'd0, 2'd2, 0, 0, 5'd4,
               pk4(48'hFFFF_FFFF_FFE8, 48'hFFFF_FFFF_FFE9, 48'h18, 48'hFFFF_FFFF_FFD8), r, u);
        chk64("R4 ties away signed", r, 64'hFFFD_0002_FFFF_FFFE);
    endtask

    task automatic t_even;
        logic [63:0] r; logic u;
        run_op(0, 3'd3, 2'd3, 0, 0, 5'd4, pk4(48'h18, 48'h28, 48'h29, 48'h37), r, u);
        chk64("R5 even unsigned", r, 64'h0003_0003_0002_0002);
        run_op(0, 3'd2, 2'd2, 0, 0, 5'd4,
               pk4(48'hFFFF_FFFF_FFE8, 48'hFFFF_FFFF_FFD8, 48'hFFFF_FFFF_FFE9, 48'h28), r, u);
        chk64("R5 even signed", r, 64'h0002_FFFF_FFFE_FFFE);
    endtask

    task automatic t_trunc;
        logic [63:0] r; logic u;
        run_op(0, 3'd4, 2'd2, 0, 0, 5'd4,
               pk4(48'hFFFF_FFFF_FFE9, 48'h2F, 48'hFFFF_FFFF_FFFF, 48'h0), r, u);
        chk64("R6 truncate signed", r, 64'h0000_FFFF_0002_FFFE);
        run_op(0, 3'd5, 2'd2, 0, 0, 5'd4, pk4(48'h2F, 48'hFFFF_FFFF_FFF0, 48'h10, 48'h0), r, u);
        chk64("R6 truncate unsigned", r, 64'h0000_0001_FFFF_0002);
    endtask

    task automatic t_clamp;
        logic [63:0] r; logic u;
        run_op(0, 3'd0, 2'd2, 0, 0, 5'd0,
               pk4(48'h9C40, 48'hFFFF_FFFF_63C0, 48'h7FFF, 48'hFFFF_FFFF_8000), r, u);
        chk64("R7 signed clamp", r, 64'h8000_7FFF_8000_7FFF);
        run_op(0, 3'd1, 2'd2, 0, 0, 5'd0,
               pk4(48'h1_0000, 48'hFFFF, 48'h1234, 48'hFFFF_FFFF_FFFF), r, u);
        chk64("R7 unsigned clamp", r, 64'hFFFF_1234_FFFF_FFFF);
        run_op(0, 3'd0, 2'd2, 0, 0, 5'd1,
               pk4(48'hFFFF, 48'hFFFF_FFFF_FFFF, 48'h3, 48'h0), r, u);
        chk64("R7 carry before clamp", r, 64'h0000_0002_FFFF_7FFF);
    endtask

    task automatic t_limits;
        logic [63:0] r; logic u;
        run_op(0, 3'd4, 2'd0, 0, {16'd47, 16'd48, 16'd47, 16'd48}, 0,
               pk4(48'h8000_0000_0000, 48'h8000_0000_0000, 48'h8000_0000_0000, 48'h8000_0000_0000), r, u);
        chk64("R8 signed truncate beyond 47", r, 64'hFFFF_0000_FFFF_0000);
        run_op(0, 3'd1, 2'd0, 0, {16'd49, 16'd48, 16'd48, 16'd48}, 0,
               pk4(48'h8000_0000_0000, 48'h7FFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF), r, u);
        chk64("R9 away unsigned at 48, R8 at 49", r, 64'h0000_0001_0000_0001);
        run_op(0, 3'd3, 2'd0, 0, {4{16'd48}},  0,
               pk4(48'h8000_0000_0000, 48'h8000_0000_0001, 48'h7FFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF), r, u);
        chk64("R9 even unsigned at 48", r, 64'h0001_0000_0001_0000);
        run_op(0, 3'd5, 2'd0, 0, {4{16'd48}},  0,
               pk4(48'h8000_0000_0000, 48'h8000_0000_0001, 48'h7FFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF), r, u);
        chk64("R9 truncate unsigned at 48", r, 64'h0001_0000_0001_0000);
    endtask

    task automatic t_sources;
        logic [63:0] r; logic u;
        run_op(0, 3'd5, 2'd1, 3'd2, {16'd8, 16'd4, 16'd0, 16'd0}, 0,
               pk4(48'h10, 48'h20, 48'h30, 48'h40), r, u);
        chk64("R10 broadcast field", r, 64'h0004_0003_0002_0001);
        run_op(0, 3'd5, 2'd0, 0, {16'd1, 16'd8, 16'd4, 16'd0}, 0,
               pk4(48'h10, 48'h20, 48'h300, 48'h40), r, u);
        chk64("R10 per-lane fields", r, 64'h0020_0003_0002_0010);
    endtask

    task automatic t_byte;
        logic [63:0] r; logic u;
        run_op(1, 3'd1, 2'd2, 0, 0, 5'd2,
               pk8(24'h6, 24'h5, 24'h3FF, 24'hFFFFFF, 24'hA, 24'h0, 24'h2, 24'h400), r, u);
        chk64("R11 byte ties away", r, 64'hFF01_0003_FFFF_0102);
        run_op(1, 3'd3, 2'd2, 0, 0, 5'd2,
               pk8(24'h6, 24'hA, 24'hB, 24'h2, 0, 0, 0, 0), r, u);
        chk64("R11 byte ties even", r, 64'h0000_0000_0003_0202);
        run_op(1, 3'd0, 2'd2, 0, 0, 5'd2, pk8(24'h6, 0, 0, 0, 0, 0, 0, 0), r, u);
        chk64("R11 byte signed mode filler", r, 64'hADAD_ADAD_ADAD_ADAD);
        chk1("R11 byte signed mode flag", u, 1'b1);
        run_op(0, 3'd6, 2'd2, 0, 0, 5'd0, pk4(48'h1, 48'h2, 48'h3, 48'h4), r, u);
        chk64("R11 code 6 filler", r, 64'hDEAD_DEAD_DEAD_DEAD);
        chk1("R11 code 6 flag", u, 1'b1);
    endtask

    task automatic t_neg_shift;
        logic [63:0] r; logic u;
        run_op(0, 3'd5, 2'd0, 0, {16'h8000, 16'd0, 16'hFFFF, 16'd4}, 0,
               pk4(48'h40, 48'h40, 48'h7, 48'h9), r, u);
        chk64("R12 negative shift lanes", r, 64'hDEAD_0007_DEAD_0004);
        chk1("R12 negative shift flag", u, 1'b1);
    endtask

    task automatic t_byte_edges;
        logic [63:0] r; logic u;
        run_op(1, 3'd1, 2'd0, 0, {8'd0, 8'd0, 8'd0, 8'hFF, 8'd23, 8'd25, 8'd24, 8'd24}, 0,
               pk8(24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 0, 0, 0), r, u);
        chk64("R9 R8 byte away at 24/25", r, 64'h0000_0000_0200_0001);
        chk1("R12 byte shift never flags", u, 1'b0);
        run_op(1, 3'd5, 2'd0, 0, {40'd0, 8'd23, 8'd0, 8'd24}, 0,
               pk8(24'hFFFFFF, 24'h12, 24'hFFFFFF, 0, 0, 0, 0, 0), r, u);
        chk64("R13 byte truncate at 24", r, 64'h0000_0000_0001_1200);
        run_op(1, 3'd5, 2'd2, 0, 0, 5'd30,
               pk8(24'hFFFFFF, 24'h800000, 24'h1, 24'h7, 24'hFFFFFF, 24'h3, 24'h5, 24'h9), r, u);
        chk64("R13 byte truncate immediate 30", r, 64'd0);
        run_op(1, 3'd3, 2'd0, 0, {48'd0, 8'd24, 8'd24}, 0,
               pk8(24'h800001, 24'h800000, 0, 0, 0, 0, 0, 0), r, u);
        chk64("R9 byte even at 24", r, 64'h0000_0000_0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_away_unsigned();
        t_away_signed();
        t_even();
        t_trunc();
        t_clamp();
        t_limits();
        t_sources();
        t_byte();
        t_neg_shift();
        t_byte_edges();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule